// File: doc/BRIEF.md
# Bit-Serial Rank-Order Sorter

This block sorts a window of `M` unsigned `N`-bit words. It does not use a network of comparators. The whole window is captured in one cycle. The words are then walked one bit column per cycle, starting at the most significant bit. There is one rank unit for each output position. Rank unit `k` decides each of its output bits with a threshold vote: the bit is 1 when at least `k` of the `M` effective column bits are 1.

Each rank unit keeps a small override state for every word. A word that is already known to lie above the rank being built is treated as all ones for the rest of the pass. A word known to lie below it is treated as all zeros. The override is what keeps later votes consistent with the bits already emitted.

Rank unit `k` runs one cycle behind rank unit `k-1`, so the output streams are skewed by one cycle per rank. The whole sorted set is out after `M+N-1` cycles. The default parameters are 8 words of 8 bits. The parameters also cover a 63-word window of 16-bit words, which takes 78 cycles.

The input side is a plain `start` pulse with the parallel window. The outputs are bit streams, each with its own valid, and they have no ready. Once a stream has begun it cannot be stalled, so a consumer must take one bit per cycle while valid is high.

Top module: `srt_rank_sorter`

## Requirements
- R1: When `start` is high and `busy` is low, the window on `in_words` is captured at that clock edge, and `busy` is high from the next cycle. Word `i` occupies bits `[i*N +: N]`.
- R2: A `start` that arrives while `busy` is high is ignored. The running sort finishes with the results of the window captured first.
- R3: Stream `g` (bit `g` of `out_bits`) carries the value of rank `g+1`, with rank 1 being the largest word. Bits come most significant first. Equal words appear as repeated values at adjacent ranks.
- R4: Calling the first cycle after the capture edge cycle 1, `out_valid[g]` is high for exactly `N` consecutive cycles, from cycle `g+1` through cycle `g+N`.
- R5: `done` is high for exactly one cycle, cycle `M+N-1`. That cycle carries the last bit of the final rank, and `busy` is low in the following cycle.
- R6: After reset, `busy`, `done` and every `out_valid` bit are low.
- R7: Any bit of `out_bits` whose `out_valid` bit is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the window when idle |
| in_words | input | M*N | Window of M unsigned words, word i at [i*N +: N] |
| busy | output | 1 | A sort is in progress |
| done | output | 1 | Pulse on the cycle of the final output bit |
| out_bits | output | M | Serial output bit per rank, bit g is rank g+1 |
| out_valid | output | M | Valid per rank stream |

## Verification
The bench targets windows where the override state matters most: all zeros, all ones, every word equal, words in pairs, and one extreme word among many small ones.
- A unit that forgets a forced word, or forces it the wrong way, produces a value at some middle rank that matches no input word.
- A wrong threshold comparison shifts every rank by one place.
- A skew or counter error shows up as a first bit, a run length, or a `done` cycle that misses its fixed cycle number.
- A start that is not ignored while busy mixes bits from two windows.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // Per-word override held by each rank unit
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_HIGH = 2'd1,
    OVR_LOW  = 2'd2
  } ovr_t;

endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl #(
  parameter int M = 8,
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [M*N-1:0] in_words,
  output logic           busy,
  output logic           done,
  output logic           clear,
  output logic           act_first,
  output logic [M-1:0]   column
);
  localparam int LAST = M + N - 1;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [N-1:0]  word_q [M];
  logic          accept;

  assign accept = start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
    end else if (busy_q) begin
      if (cnt_q == CW'(LAST)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // Word registers shift left so that the live column is always the top bit
  for (genvar i = 0; i < M; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[i] <= '0;
      end else if (accept) begin
        word_q[i] <= in_words[i*N +: N];
      end else if (busy_q) begin
        word_q[i] <= word_q[i] << 1;
      end
    end
    assign column[i] = word_q[i][N-1];
  end

  assign busy      = busy_q;
  assign clear     = accept;
  assign act_first = busy_q && (cnt_q <= CW'(N));
  assign done      = busy_q && (cnt_q == CW'(LAST));

endmodule

// File: rtl/srt_rank_unit.sv
module srt_rank_unit
  import srt_pkg::*;
#(
  parameter int M = 8,
  parameter int K = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         act,
  input  logic [M-1:0] col,
  output logic         bit_o,
  output logic         valid_o
);
  localparam int CW = $clog2(M + 1);

  ovr_t          st_q [M];
  logic [M-1:0]  eff;
  logic [CW-1:0] ones;
  logic          vote;

  for (genvar i = 0; i < M; i++) begin : g_eff
    assign eff[i] = (st_q[i] == OVR_HIGH) ? 1'b1 :
                    (st_q[i] == OVR_LOW)  ? 1'b0 : col[i];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < M; i++) begin
      ones = ones + CW'(eff[i]);
    end
  end

  assign vote = (ones >= CW'(K));

  for (genvar i = 0; i < M; i++) begin : g_state
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= OVR_NONE;
      end else if (clear) begin
        st_q[i] <= OVR_NONE;
      end else if (act && st_q[i] == OVR_NONE) begin
        if (col[i] && !vote) begin
          st_q[i] <= OVR_HIGH;
        end else if (!col[i] && vote) begin
          st_q[i] <= OVR_LOW;
        end
      end
    end
  end

  assign bit_o   = act && vote;
  assign valid_o = act;

endmodule

// File: rtl/srt_rank_sorter.sv
module srt_rank_sorter #(
  parameter int M = 8,
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [M*N-1:0] in_words,
  output logic           busy,
  output logic           done,
  output logic [M-1:0]   out_bits,
  output logic [M-1:0]   out_valid
);
  logic         clear;
  logic [M-1:0] col_ch [M];
  logic         act_ch [M];

  srt_ctrl #(.M(M), .N(N)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_words  (in_words),
    .busy      (busy),
    .done      (done),
    .clear     (clear),
    .act_first (act_ch[0]),
    .column    (col_ch[0])
  );

  // One-cycle delay per rank for both the column and the active flag
  for (genvar g = 1; g < M; g++) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        col_ch[g] <= '0;
        act_ch[g] <= 1'b0;
      end else begin
        col_ch[g] <= col_ch[g-1];
        act_ch[g] <= act_ch[g-1];
      end
    end
  end

  for (genvar g = 0; g < M; g++) begin : g_rank
    srt_rank_unit #(.M(M), .K(g + 1)) unit_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .act     (act_ch[g]),
      .col     (col_ch[g]),
      .bit_o   (out_bits[g]),
      .valid_o (out_valid[g])
    );
  end

endmodule

// File: rtl/srt_rank_sorter_chk.sv
module srt_rank_sorter_chk #(
  parameter int M = 8,
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [M-1:0]   out_valid
);
  localparam int LW = $clog2(N + 2);
  logic [LW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (out_valid[0]) begin
      run_q <= run_q + LW'(1);
    end else begin
      run_q <= '0;
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (start && busy && !done) |=> busy); // R2
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) (!out_valid[0] && run_q != '0) |-> (run_q == LW'(N))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n) done |-> out_valid[M-1]); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!busy && out_valid == '0)); // R5

  for (genvar g = 1; g < M; g++) begin : g_skew
    AST_SKEW_STEP: assert property (@(posedge clk) disable iff (!rst_n) out_valid[g] == $past(out_valid[g-1])); // R4
  end

endmodule

bind srt_rank_sorter srt_rank_sorter_chk #(.M(M), .N(N)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .out_valid (out_valid)
);

// File: tb/srt_rank_sorter_tb_top.sv
module srt_rank_sorter_tb_top;
  localparam int  M = 8;
  localparam int  N = 8;
  localparam time CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [M*N-1:0] in_words = '0;
  logic           busy, done;
  logic [M-1:0]   out_bits, out_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [M*N-1:0] exp_q [$];

  srt_rank_sorter #(.M(M), .N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_words(in_words),
    .busy(busy), .done(done), .out_bits(out_bits), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [M*N-1:0] ref_sort(input logic [M*N-1:0] f);
    logic [N-1:0] v [M];
    logic [N-1:0] t;
    logic [M*N-1:0] r;
    for (int i = 0; i < M; i++) v[i] = f[i*N +: N];
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M - 1 - i; j++)
        if (v[j] < v[j+1]) begin
          t = v[j]; v[j] = v[j+1]; v[j+1] = t;
        end
    for (int i = 0; i < M; i++) r[i*N +: N] = v[i];
    return r;
  endfunction

  // Driver: push expected sort, then pulse start
  task automatic run_window(input logic [M*N-1:0] w);
    while (busy) @(negedge clk);
    in_words = w;
    start = 1'b1;
    exp_q.push_back(ref_sort(w));
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
  endtask

  // Monitor: reassemble streams and compare at done
  logic [N-1:0] acc [M];
  int  nb [M];
  int  base = 0;
  bit  pbusy = 1'b0;
  bit  want_idle = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (want_idle) begin
        chk(!busy, "R5", "busy after done", busy, 0);
        want_idle = 1'b0;
      end
      if (busy && !pbusy) begin
        base = cyc;
        for (int g = 0; g < M; g++) begin acc[g] = '0; nb[g] = 0; end
      end
      for (int g = 0; g < M; g++) begin
        if (out_valid[g]) begin
          if (nb[g] == 0) chk(cyc == base + g, "R4", $sformatf("first bit rank %0d", g + 1), cyc - base, g);
          acc[g] = (acc[g] << 1) | N'(out_bits[g]);
          nb[g]++;
        end else begin
          chk(out_bits[g] == 1'b0, "R7", $sformatf("idle bit rank %0d", g + 1), out_bits[g], 0);
        end
      end
      if (done) begin
        logic [M*N-1:0] e;
        chk(cyc == base + M + N - 2, "R5", "done cycle", cyc - base + 1, M + N - 1);
        chk(out_valid[M-1] == 1'b1, "R5", "last rank valid at done", out_valid[M-1], 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected result", 1, 0);
        end else begin
          e = exp_q.pop_front();
          for (int g = 0; g < M; g++) begin
            chk(acc[g] == e[g*N +: N], "R3", $sformatf("rank %0d value", g + 1), acc[g], e[g*N +: N]);
            chk(nb[g] == N, "R4", $sformatf("rank %0d bit count", g + 1), nb[g], N);
          end
        end
        want_idle = 1'b1;
      end
      pbusy = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [M*N-1:0] w, w2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R6", "busy after reset", busy, 0);
    chk(done == 1'b0, "R6", "done after reset", done, 0);
    chk(out_valid == '0, "R6", "valid after reset", out_valid, 0);

    run_window('0);                           // R3 all zero
    run_window('1);                           // R3 all ones
    for (int i = 0; i < M; i++) w[i*N +: N] = N'(8'h5A);
    run_window(w);                            // R3 all equal
    for (int i = 0; i < M; i++) w[i*N +: N] = N'((i / 2) * 37 + 3);
    run_window(w);                            // R3 pairs
    for (int i = 0; i < M; i++) w[i*N +: N] = N'(i);
    run_window(w);                            // ascending
    for (int i = 0; i < M; i++) w[i*N +: N] = N'(M - i);
    run_window(w);                            // descending
    w = '0; w[3*N +: N] = '1;
    run_window(w);                            // one max among zeros
    w = '1; w[5*N +: N] = '0;
    run_window(w);                            // one zero among max

    // R2: start during a busy pass must be ignored
    for (int i = 0; i < M; i++) w[i*N +: N] = N'($urandom);
    for (int i = 0; i < M; i++) w2[i*N +: N] = N'($urandom);
    run_window(w);
    repeat (3) @(negedge clk);
    in_words = w2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy through ignored start", busy, 1);
    chk(exp_q.size() == 1, "R2", "no extra window queued", exp_q.size(), 1);

    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < M; i++) w[i*N +: N] = N'($urandom);
      if (r % 4 == 0) w[N +: N] = w[0 +: N];
      run_window(w);
    end

    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule